// File: doc/BRIEF.md
# Byte-Lane Finite-Field Vector Unit

This block is a lane-parallel arithmetic unit for the field GF(2^8). A wide vector is split into independent 8-bit lanes. Every lane runs one of three operations, selected by a shared opcode:

- **Field multiply** of two bytes, reduced by the fixed polynomial 0x11B.
- **Bit-matrix affine transform** of a byte: an 8x8 matrix over GF(2), followed by an XOR constant.
- **Field inversion followed by that affine transform.** With the standard cipher matrix and the constant 0x63, this gives the AES substitution box.

The unit accepts one operation per clock. The result vector and its valid flag are registered and appear on the cycle after the request.

The matrix operand is as wide as the data vector. Each 64-bit group of it holds the matrix for the eight byte lanes of the same group. This lets one request apply different bit transforms to different parts of the vector. The field inverse is built from logic, by raising the byte to the power 254, so no lookup table is loaded.

Top module: `gf8_vector_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: With opcode 2'b00, each result lane equals the carry-less product of the matching `src_a` and `src_b` lanes, reduced modulo x^8+x^4+x^3+x+1 (for example 0x57 times 0x83 gives 0xC1).
- R3: With opcode 2'b01, bit i of a result lane is the XOR-parity of (matrix row i AND the `src_a` lane), XORed with `affine_const[i]`. Row i is byte (7-i), bits [8*(7-i)+7 : 8*(7-i)], of the lane's 64-bit matrix group.
- R4: With opcode 2'b10, each lane is first replaced by its field inverse and then put through the R3 affine transform. The matrix 64'hF1E3C78F1F3E7CF8 with constant 0x63 gives the AES S-box: 0x00 gives 0x63, 0x53 gives 0xED, 0x01 gives 0x7C, 0xFF gives 0x16.
- R5: The inverse of 0x00 is taken as 0x00. For every nonzero byte x, the inverse y satisfies x times y = 0x01.
- R6: Lanes are independent. Lane l uses matrix group l/8, so different groups can apply different matrices in the same request.
- R7: A request with `in_valid` high produces `out_valid` high, with its result, exactly one clock later. Back-to-back requests on consecutive cycles each produce their own result.
- R8: While `in_valid` is low, `out_valid` is 0 on the following cycle and `result` keeps its previous value.
- R9: `src_b` has no effect on opcodes 2'b01 and 2'b10.
- R10: Opcode 2'b11 is reserved. It produces an all-zero result with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 2 | 00 multiply, 01 affine, 10 inverse-then-affine, 11 reserved |
| src_a | input | VEC_W | First operand, byte lanes |
| src_b | input | VEC_W | Second operand (multiply only) |
| matrix | input | VEC_W | One 8x8 bit matrix per 64-bit group |
| affine_const | input | 8 | Constant XORed after the matrix product |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | VEC_W | Registered result lanes |

## Verification
The hardest case to reach from the ports is a full sweep of the inversion path over all 256 byte values. Each value must be checked under both the identity matrix and the cipher matrix. The stimulus packs the whole byte range into four 64-lane requests. It compares every lane against a brute-force inverse and against known S-box entries. Separate requests then load different matrices into each 64-bit group, so that a lane wired to the wrong group would show up.

// File: rtl/gfv_pkg.sv
// Package: shared opcode type and GF(2^8) helper functions.
// Assumes the fixed reduction polynomial 0x11B.
package gfv_pkg;

    typedef enum logic [1:0] {
        OP_MUL    = 2'b00,
        OP_AFF    = 2'b01,
        OP_INVAFF = 2'b10,
        OP_RSVD   = 2'b11
    } gfv_op_e;

    localparam logic [7:0] POLY_LOW = 8'h1B;

    // Shift-and-XOR field multiply with reduction folded into each shift.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? POLY_LOW : 8'h00);
        end
        return acc;
    endfunction

    // Bit-matrix times byte over GF(2). Row i sits in byte (7-i).
    function automatic logic [7:0] gf_affine(input logic [63:0] m, input logic [7:0] x,
                                             input logic [7:0] c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = (^(m[8*(7-i) +: 8] & x)) ^ c[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gfv_inverse.sv
// Module: field inverse of one byte, computed as x^254.
// Assumes: purely combinational; 0x00 maps to 0x00 by the arithmetic itself.
module gfv_inverse
    import gfv_pkg::*;
(
    input  logic [7:0] x,
    output logic [7:0] inv
);

    // Square seven times, accumulating x^2 * x^4 * ... * x^128 = x^254.
    always_comb begin
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = x;
        acc = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        inv = acc;
    end

    // The power chain must agree with the shift-XOR multiplier.
    always_comb begin
        if (x != 8'h00) begin
            assert_inverse_R5: assert (gf_mul(x, inv) == 8'h01)
                else $error("inverse product not one");
        end
    end

endmodule

// File: rtl/gfv_lane.sv
// Module: one byte lane. It selects multiply, affine or inverse-then-affine.
// Assumes: the caller has already picked this lane's 64-bit matrix group.
module gfv_lane
    import gfv_pkg::*;
(
    input  logic [1:0]  op,
    input  logic [7:0]  a,
    input  logic [7:0]  b,
    input  logic [63:0] mtx,
    input  logic [7:0]  cst,
    output logic [7:0]  res
);

    logic [7:0] a_inv;

    gfv_inverse u_inv (
        .x   (a),
        .inv (a_inv)
    );

    // Operation select for this lane.
    always_comb begin
        unique case (gfv_op_e'(op))
            OP_MUL:    res = gf_mul(a, b);
            OP_AFF:    res = gf_affine(mtx, a, cst);
            OP_INVAFF: res = gf_affine(mtx, a_inv, cst);
            default:   res = 8'h00;
        endcase
    end

endmodule

// File: rtl/gf8_vector_unit.sv
// Module: lane-parallel GF(2^8) unit with a registered result.
// Assumes: VEC_W is a multiple of 64. Lane l takes its matrix from group l/8.
module gf8_vector_unit #(
    parameter int VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       opcode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] matrix,
    input  logic [7:0]       affine_const,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);

    localparam int LANES          = VEC_W / 8;
    localparam int LANES_PER_GRP  = 8;

    logic [VEC_W-1:0] lane_res;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        gfv_lane u_lane (
            .op  (opcode),
            .a   (src_a[8*l +: 8]),
            .b   (src_b[8*l +: 8]),
            .mtx (matrix[64*(l / LANES_PER_GRP) +: 64]),
            .cst (affine_const),
            .res (lane_res[8*l +: 8])
        );
    end

    // Output register: the valid flag follows the strobe, the data loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= lane_res;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0))
        else $error("output not cleared by reset");

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("valid did not follow request");

    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("valid without request");

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result))
        else $error("result changed without request");

endmodule

// File: tb/test_gf8_vector_unit.sv
// Bench: directed scenarios, one task each, with independent reference models.
module test_gf8_vector_unit;

    localparam int VEC_W = 512;
    localparam int LANES = VEC_W / 8;
    localparam int GRPS  = VEC_W / 64;
    localparam logic [63:0] M_ID  = 64'h0102040810204080;
    localparam logic [63:0] M_AES = 64'hF1E3C78F1F3E7CF8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [1:0]       opcode;
    logic [VEC_W-1:0] src_a, src_b, matrix;
    logic [7:0]       affine_const;
    logic             out_valid;
    logic [VEC_W-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    gf8_vector_unit #(.VEC_W(VEC_W)) i_gf8_vector_unit (
        .clk, .rst_n, .in_valid, .opcode, .src_a, .src_b, .matrix,
        .affine_const, .out_valid, .result
    );

    // Reference multiply: full polynomial product, then reduce from the top bit down.
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] p;
        p = '0;
        for (int j = 0; j < 8; j++) if (b[j]) p = p ^ (15'(a) << j);
        for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11B << (k - 8));
        return p[7:0];
    endfunction

    // Reference inverse by exhaustive search.
    function automatic logic [7:0] ref_inv(input logic [7:0] x);
        logic [7:0] r;
        r = 8'h00;
        for (int y = 1; y < 256; y++) if (ref_mul(x, 8'(y)) == 8'h01) r = 8'(y);
        return r;
    endfunction

    // Reference affine: bit-by-bit dot products.
    function automatic logic [7:0] ref_aff(input logic [63:0] m, input logic [7:0] x,
                                           input logic [7:0] c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = c[i];
            for (int j = 0; j < 8; j++) r[i] = r[i] ^ (m[8*(7-i) + j] & x[j]);
        end
        return r;
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check_vec(input string req, input logic [VEC_W-1:0] got,
                             input logic [VEC_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_byte(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one request for one cycle and return at the next falling edge, after the register.
    task automatic run_op(input logic [1:0] op, input logic [VEC_W-1:0] a,
                          input logic [VEC_W-1:0] b, input logic [VEC_W-1:0] m,
                          input logic [7:0] c);
        @(negedge clk);
        opcode = op; src_a = a; src_b = b; matrix = m; affine_const = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [VEC_W-1:0] rand_vec();
        logic [VEC_W-1:0] v;
        for (int w = 0; w < VEC_W / 32; w++) v[32*w +: 32] = next_rand();
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] rep_mtx(input logic [63:0] m);
        logic [VEC_W-1:0] v;
        for (int g = 0; g < GRPS; g++) v[64*g +: 64] = m;
        return v;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; opcode = 2'b00;
        src_a = '1; src_b = '1; matrix = '0; affine_const = 8'h00;
        repeat (3) @(negedge clk);
        check_byte("R1 out_valid in reset", {7'b0, out_valid}, 8'h00);
        check_vec("R1 result in reset", result, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_byte("R1 out_valid after reset", {7'b0, out_valid}, 8'h00);
        check_vec("R1 result after reset", result, '0);
    endtask

    task automatic t_multiply();
        logic [VEC_W-1:0] a, b, e;
        a = rand_vec(); b = rand_vec();
        a[7:0] = 8'h57; b[7:0] = 8'h83;
        a[15:8] = 8'h80; b[15:8] = 8'h02;
        for (int l = 0; l < LANES; l++) e[8*l +: 8] = ref_mul(a[8*l +: 8], b[8*l +: 8]);
        run_op(2'b00, a, b, rand_vec(), 8'h5A);
        check_vec("R2 multiply random", result, e);
        check_byte("R2 0x57*0x83", result[7:0], 8'hC1);
        check_byte("R2 0x80*0x02", result[15:8], 8'h1B);
        check_byte("R7 valid after multiply", {7'b0, out_valid}, 8'h01);
        for (int l = 0; l < LANES; l++) begin
            a[8*l +: 8] = 8'(l * 4 + 3);
            b[8*l +: 8] = 8'(8'hFF - l);
            e[8*l +: 8] = ref_mul(a[8*l +: 8], b[8*l +: 8]);
        end
        run_op(2'b00, a, b, '0, 8'h00);
        check_vec("R2 multiply ramp", result, e);
    endtask

    task automatic t_affine();
        logic [VEC_W-1:0] a, m, e;
        logic [7:0] c;
        a = rand_vec(); m = rand_vec(); c = 8'hA6;
        for (int l = 0; l < LANES; l++)
            e[8*l +: 8] = ref_aff(m[64*(l/8) +: 64], a[8*l +: 8], c);
        run_op(2'b01, a, rand_vec(), m, c);
        check_vec("R3 R6 affine per-group matrices", result, e);
        run_op(2'b01, a, '0, rep_mtx(M_ID), 8'h00);
        check_vec("R3 identity matrix", result, a);
    endtask

    task automatic t_sbox();
        logic [VEC_W-1:0] a, e;
        for (int blk = 0; blk < 4; blk++) begin
            for (int l = 0; l < LANES; l++) begin
                a[8*l +: 8] = 8'(blk * LANES + l);
                e[8*l +: 8] = ref_aff(M_AES, ref_inv(8'(blk * LANES + l)), 8'h63);
            end
            run_op(2'b10, a, rand_vec(), rep_mtx(M_AES), 8'h63);
            check_vec("R4 S-box sweep", result, e);
            if (blk == 0) begin
                check_byte("R4 sbox(00)", result[7:0], 8'h63);
                check_byte("R4 sbox(01)", result[15:8], 8'h7C);
            end
            if (blk == 1) check_byte("R4 sbox(53)", result[8*19 +: 8], 8'hED);
            if (blk == 3) check_byte("R4 sbox(FF)", result[8*63 +: 8], 8'h16);
        end
    endtask

    task automatic t_inverse();
        logic [VEC_W-1:0] a, e;
        for (int blk = 0; blk < 4; blk++) begin
            for (int l = 0; l < LANES; l++) begin
                a[8*l +: 8] = 8'(blk * LANES + l);
                e[8*l +: 8] = ref_inv(8'(blk * LANES + l));
            end
            run_op(2'b10, a, '0, rep_mtx(M_ID), 8'h00);
            check_vec("R5 raw inverse sweep", result, e);
            if (blk == 0) check_byte("R5 inverse of zero", result[7:0], 8'h00);
            for (int l = 0; l < LANES; l++) begin
                if (a[8*l +: 8] != 8'h00)
                    check_byte("R5 x*inv(x)", ref_mul(a[8*l +: 8], result[8*l +: 8]), 8'h01);
            end
        end
    endtask

    task automatic t_back_to_back();
        logic [VEC_W-1:0] a1, b1, a2, e1, e2;
        a1 = rand_vec(); b1 = rand_vec(); a2 = rand_vec();
        for (int l = 0; l < LANES; l++) begin
            e1[8*l +: 8] = ref_mul(a1[8*l +: 8], b1[8*l +: 8]);
            e2[8*l +: 8] = ref_aff(M_AES, a2[8*l +: 8], 8'h0F);
        end
        @(negedge clk);
        opcode = 2'b00; src_a = a1; src_b = b1; matrix = '0; affine_const = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        check_vec("R7 first of pair", result, e1);
        check_byte("R7 valid first", {7'b0, out_valid}, 8'h01);
        opcode = 2'b01; src_a = a2; matrix = rep_mtx(M_AES); affine_const = 8'h0F;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R7 second of pair", result, e2);
        check_byte("R7 valid second", {7'b0, out_valid}, 8'h01);
    endtask

    task automatic t_hold();
        logic [VEC_W-1:0] kept;
        kept = result;
        @(negedge clk);
        opcode = 2'b00; src_a = rand_vec(); src_b = rand_vec();
        @(negedge clk);
        check_byte("R8 valid low when idle", {7'b0, out_valid}, 8'h00);
        check_vec("R8 result held when idle", result, kept);
        src_a = rand_vec();
        @(negedge clk);
        check_vec("R8 result still held", result, kept);
    endtask

    task automatic t_ignore_b();
        logic [VEC_W-1:0] a, m, r1;
        a = rand_vec(); m = rand_vec();
        run_op(2'b01, a, '0, m, 8'h33);
        r1 = result;
        run_op(2'b01, a, '1, m, 8'h33);
        check_vec("R9 affine ignores src_b", result, r1);
        run_op(2'b10, a, '0, m, 8'h33);
        r1 = result;
        run_op(2'b10, a, rand_vec(), m, 8'h33);
        check_vec("R9 inverse-affine ignores src_b", result, r1);
    endtask

    task automatic t_reserved();
        run_op(2'b00, {LANES{8'h03}}, {LANES{8'h05}}, '0, 8'h00);
        check_vec("R10 nonzero before reserved", result, {LANES{8'h0F}});
        run_op(2'b11, rand_vec(), rand_vec(), rand_vec(), 8'hFF);
        check_vec("R10 reserved opcode gives zero", result, '0);
        check_byte("R10 reserved valid", {7'b0, out_valid}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_multiply();
        t_affine();
        t_sbox();
        t_inverse();
        t_back_to_back();
        t_hold();
        t_ignore_b();
        t_reserved();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule